// File: doc/BRIEF.md
# Index/Data Configuration Register Port

This block gives a host a window into a small 8-bit configuration space through two adjacent byte addresses in I/O space. The lower address holds a pointer; the upper address reads or writes whichever configuration register the pointer selects. A strap input, captured while reset is held, picks which of two fixed address pairs the port answers on. Cycle decoding of the host bus is done elsewhere. This block sees only a 16-bit address, a read strobe, a write strobe and byte-wide data, and it returns read data one clock later together with a valid flag.

The configuration space has a few kinds of register. A device-number register, a device ID and a revision ID are always reachable. The device-specific registers are reachable only while the device-number register holds the block's own number. These are the activate bit, a 16-bit I/O base descriptor, an interrupt selection byte and an interrupt type byte. The block drives the activate bit, the decoded I/O base with its valid flag, and both interrupt bytes to neighbouring logic.

Top module: `cfg_idx_port`

## Requirements
- R1: A write to the pointer address (base+0) loads the 8-bit pointer, which resets to 00h. A read of base+0 returns the pointer.
- R2: The port base is sampled from `strap_hi` on each clock edge while `rst_n` is low, and held after reset is released. High selects 007Eh/007Fh and low selects 00EEh/00EFh. Any other address gives no response: reads return `io_rvalid`=0 and `io_rdata`=00h, and writes change nothing.
- R3: Through the data address (base+1), pointer 07h is a read/write device-number register that resets to 00h. Pointer 20h reads a fixed FEh and pointer 27h reads the `REV_ID` parameter (default 11h). Writes to 20h and 27h have no effect.
- R4: Pointers 30h through 71h are reachable only while the device-number register equals 1Ah. Otherwise they read 00h and writes to them are ignored.
- R5: Pointer 30h implements only bit 0, which is the activate bit. It resets to 0, reads back as {7'b0, act}, and drives `dev_active`.
- R6: Pointer 60h holds base bits 15:8 and pointer 61h holds base bits 7:0. Bits 3:0 of 61h always read 0 and both registers reset to 00h. `io_base` is {60h, 61h}, and `io_base_vld` equals the activate bit.
- R7: Pointer 70h is a full read/write byte that resets to 00h and drives `irq_sel`. Bits 3:0 carry the interrupt number and bit 4 carries the wake enable.
- R8: Pointer 71h resets to 03h. Only bit 1 is writable; bit 0 reads 1 and bits 7:2 read 0. Its value drives `irq_type`.
- R9: A data read at an unimplemented pointer returns 00h. A data write at an unimplemented pointer is ignored.
- R10: A read strobe at base+0 or base+1 gives `io_rvalid`=1 with the data on the next clock. Otherwise `io_rvalid`=0 and `io_rdata`=00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| strap_hi | input | 1 | Base select strap: 1 selects 007Eh, 0 selects 00EEh |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid the cycle after `io_rd` |
| io_rvalid | output | 1 | The port answered the previous read |
| dev_active | output | 1 | Activate bit |
| io_base | output | 16 | Decoded I/O base of the device |
| io_base_vld | output | 1 | `io_base` is in use (device active) |
| irq_sel | output | 8 | Interrupt number and wake enable byte |
| irq_type | output | 8 | Interrupt type byte |

## Verification
The assertions take for granted that a read strobe and a write strobe are never high in the same cycle. They also assume each strobe stands for exactly one access, so a strobe held over two cycles counts as two accesses. The address is taken to be stable for the cycle in which a strobe is high. The stimulus issues every access as a single strobe cycle framed by idle cycles, and it never asserts both strobes together. It also changes the strap only after reset has been released, which checks that the captured base does not follow the strap.

// File: rtl/cfg_idx_pkg.sv
package cfg_idx_pkg;

    localparam int CFG_DW = 8;
    typedef logic [CFG_DW-1:0] cbyte_t;

    // Pointer values of the implemented configuration registers
    localparam cbyte_t IDX_DEVNUM = 8'h07;
    localparam cbyte_t IDX_DEVID  = 8'h20;
    localparam cbyte_t IDX_REVID  = 8'h27;
    localparam cbyte_t IDX_ACT    = 8'h30;
    localparam cbyte_t IDX_BASEH  = 8'h60;
    localparam cbyte_t IDX_BASEL  = 8'h61;
    localparam cbyte_t IDX_IRQSEL = 8'h70;
    localparam cbyte_t IDX_IRQTYP = 8'h71;

    localparam cbyte_t GATE_LO    = 8'h30;
    localparam cbyte_t GATE_HI    = 8'h71;
    localparam cbyte_t IRQTYP_RST = 8'h03;

    typedef struct packed {
        cbyte_t      ptr;
        cbyte_t      devnum;
        logic        act;
        cbyte_t      base_h;
        logic [3:0]  base_l;
        cbyte_t      irqsel;
        logic        irqtyp1;
        cbyte_t      rdata;
        logic        rvalid;
    } bank_t;

    function automatic logic [15:0] pick_base(input logic sel,
                                              input logic [15:0] hi_base,
                                              input logic [15:0] lo_base);
        return sel ? hi_base : lo_base;
    endfunction

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
    import cfg_idx_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE_HI = 16'h007E,
    parameter logic [ADDR_W-1:0] BASE_LO = 16'h00EE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hi,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              idx_hit,
    output logic              data_hit,
    output logic              base_sel_q
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              base_sel_d;
    logic [ADDR_W-1:0] base_now;

    // Strap follows the pin while reset is held, then freezes
    always_comb begin
        base_sel_d = rst_n ? base_sel_q : strap_hi;
    end

    always_ff @(posedge clk) begin
        base_sel_q <= base_sel_d;
    end

    always_comb begin
        base_now = pick_base(base_sel_q, BASE_HI, BASE_LO);
        idx_hit  = (io_addr == base_now);
        data_hit = (io_addr == (base_now + ONE));
    end

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
    import cfg_idx_pkg::*;
#(
    parameter cbyte_t DEVNUM_ID = 8'h1A,
    parameter cbyte_t DEV_ID    = 8'hFE,
    parameter cbyte_t REV_ID    = 8'h11
) (
    input  cbyte_t     ptr,
    input  cbyte_t     devnum,
    input  logic       act,
    input  cbyte_t     base_h,
    input  logic [3:0] base_l,
    input  cbyte_t     irqsel,
    input  logic       irqtyp1,
    output cbyte_t     rd_val
);

    logic gate_open;
    logic in_gate;

    always_comb begin
        gate_open = (devnum == DEVNUM_ID);
        in_gate   = (ptr >= GATE_LO) && (ptr <= GATE_HI);
        rd_val    = '0;
        case (ptr)
            IDX_DEVNUM: rd_val = devnum;
            IDX_DEVID:  rd_val = DEV_ID;
            IDX_REVID:  rd_val = REV_ID;
            IDX_ACT:    rd_val = {7'b0, act};
            IDX_BASEH:  rd_val = base_h;
            IDX_BASEL:  rd_val = {base_l, 4'b0000};
            IDX_IRQSEL: rd_val = irqsel;
            IDX_IRQTYP: rd_val = {6'b0, irqtyp1, 1'b1};
            default:    rd_val = '0;
        endcase
        if (in_gate && !gate_open) begin
            rd_val = '0;
        end
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_idx_pkg::*;
#(
    parameter cbyte_t DEVNUM_ID = 8'h1A
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   io_wr,
    input  logic   io_rd,
    input  cbyte_t io_wdata,
    input  logic   idx_hit,
    input  logic   data_hit,
    input  cbyte_t rd_val,
    output bank_t  st_q
);

    localparam bank_t BANK_RST = '{
        ptr:     '0,
        devnum:  '0,
        act:     1'b0,
        base_h:  '0,
        base_l:  '0,
        irqsel:  '0,
        irqtyp1: IRQTYP_RST[1],
        rdata:   '0,
        rvalid:  1'b0
    };

    bank_t st_d;
    logic  gate_open;

    always_comb begin
        st_d      = st_q;
        gate_open = (st_q.devnum == DEVNUM_ID);

        // Read return, one clock after the strobe
        st_d.rvalid = io_rd && (idx_hit || data_hit);
        if (io_rd && idx_hit) begin
            st_d.rdata = st_q.ptr;
        end else if (io_rd && data_hit) begin
            st_d.rdata = rd_val;
        end else begin
            st_d.rdata = '0;
        end

        if (io_wr && idx_hit) begin
            st_d.ptr = io_wdata;
        end

        if (io_wr && data_hit) begin
            case (st_q.ptr)
                IDX_DEVNUM: st_d.devnum = io_wdata;
                IDX_ACT: begin
                    if (gate_open) st_d.act = io_wdata[0];
                end
                IDX_BASEH: begin
                    if (gate_open) st_d.base_h = io_wdata;
                end
                IDX_BASEL: begin
                    if (gate_open) st_d.base_l = io_wdata[7:4];
                end
                IDX_IRQSEL: begin
                    if (gate_open) st_d.irqsel = io_wdata;
                end
                IDX_IRQTYP: begin
                    if (gate_open) st_d.irqtyp1 = io_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BANK_RST;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cfg_idx_port.sv
module cfg_idx_port
    import cfg_idx_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_HI   = 16'h007E,
    parameter logic [ADDR_W-1:0] BASE_LO   = 16'h00EE,
    parameter logic [7:0]        DEVNUM_ID = 8'h1A,
    parameter logic [7:0]        DEV_ID    = 8'hFE,
    parameter logic [7:0]        REV_ID    = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hi,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rvalid,
    output logic              dev_active,
    output logic [15:0]       io_base,
    output logic              io_base_vld,
    output logic [7:0]        irq_sel,
    output logic [7:0]        irq_type
);

    logic   idx_hit;
    logic   data_hit;
    logic   base_sel_q;
    cbyte_t rd_val;
    bank_t  st_q;
    cbyte_t ptr_q;
    cbyte_t devnum_q;

    cfg_addr_dec #(
        .ADDR_W  (ADDR_W),
        .BASE_HI (BASE_HI),
        .BASE_LO (BASE_LO)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_hi   (strap_hi),
        .io_addr    (io_addr),
        .idx_hit    (idx_hit),
        .data_hit   (data_hit),
        .base_sel_q (base_sel_q)
    );

    cfg_reg_bank #(
        .DEVNUM_ID (DEVNUM_ID)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .idx_hit  (idx_hit),
        .data_hit (data_hit),
        .rd_val   (rd_val),
        .st_q     (st_q)
    );

    cfg_rd_mux #(
        .DEVNUM_ID (DEVNUM_ID),
        .DEV_ID    (DEV_ID),
        .REV_ID    (REV_ID)
    ) u_mux (
        .ptr     (st_q.ptr),
        .devnum  (st_q.devnum),
        .act     (st_q.act),
        .base_h  (st_q.base_h),
        .base_l  (st_q.base_l),
        .irqsel  (st_q.irqsel),
        .irqtyp1 (st_q.irqtyp1),
        .rd_val  (rd_val)
    );

    always_comb begin
        ptr_q       = st_q.ptr;
        devnum_q    = st_q.devnum;
        io_rdata    = st_q.rdata;
        io_rvalid   = st_q.rvalid;
        dev_active  = st_q.act;
        io_base     = {st_q.base_h, st_q.base_l, 4'b0000};
        io_base_vld = st_q.act;
        irq_sel     = st_q.irqsel;
        irq_type    = {6'b0, st_q.irqtyp1, 1'b1};
    end

endmodule

// File: rtl/cfg_idx_chk.sv
module cfg_idx_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_HI   = 16'h007E,
    parameter logic [ADDR_W-1:0] BASE_LO   = 16'h00EE,
    parameter logic [7:0]        DEVNUM_ID = 8'h1A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              io_rvalid,
    input logic              dev_active,
    input logic [7:0]        ptr_q,
    input logic [7:0]        devnum_q,
    input logic              base_sel_q
);

    logic [ADDR_W-1:0] a_ptr;
    logic [ADDR_W-1:0] a_dat;
    logic              at_ptr;
    logic              at_dat;

    always_comb begin
        a_ptr  = base_sel_q ? BASE_HI : BASE_LO;
        a_dat  = a_ptr + ADDR_W'(1);
        at_ptr = (io_addr == a_ptr);
        at_dat = (io_addr == a_dat);
    end

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr)); // R10

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_ptr) |=> (ptr_q == $past(io_wdata))); // R1

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(base_sel_q)); // R2

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !at_ptr && !at_dat) |=> (!io_rvalid && io_rdata == 8'h00)); // R2

    AST_HIT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (at_ptr || at_dat)) |=> io_rvalid); // R10

    AST_GATED_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_dat && ptr_q == 8'h30 && devnum_q != DEVNUM_ID) |=> $stable(dev_active)); // R4

    AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_dat && ptr_q == 8'h30 && devnum_q == DEVNUM_ID) |=> (dev_active == $past(io_wdata[0]))); // R5

endmodule

bind cfg_idx_port cfg_idx_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_HI   (BASE_HI),
    .BASE_LO   (BASE_LO),
    .DEVNUM_ID (DEVNUM_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .io_rvalid  (io_rvalid),
    .dev_active (dev_active),
    .ptr_q      (ptr_q),
    .devnum_q   (devnum_q),
    .base_sel_q (base_sel_q)
);

// File: tb/cfg_idx_port_tb_top.sv
`timescale 1ns/1ps
module cfg_idx_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_hi = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic        dev_active;
    logic [15:0] io_base;
    logic        io_base_vld;
    logic [7:0]  irq_sel;
    logic [7:0]  irq_type;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state, built from the requirements
    logic [15:0] b_ptr, b_dat;
    logic [7:0]  m_ptr, m_dev, m_bh, m_irq;
    logic [3:0]  m_bl;
    logic        m_act, m_t1;

    always #2 clk = ~clk;

    cfg_idx_port dut_i (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_rvalid(io_rvalid), .dev_active(dev_active), .io_base(io_base),
        .io_base_vld(io_base_vld), .irq_sel(irq_sel), .irq_type(irq_type)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic gate_ok();
        return m_dev == 8'h1A;
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] p);
        logic in_gate = (p >= 8'h30) && (p <= 8'h71);
        if (in_gate && !gate_ok()) return 8'h00;
        case (p)
            8'h07: return m_dev;
            8'h20: return 8'hFE;
            8'h27: return 8'h11;
            8'h30: return {7'b0, m_act};
            8'h60: return m_bh;
            8'h61: return {m_bl, 4'h0};
            8'h70: return m_irq;
            8'h71: return {6'b0, m_t1, 1'b1};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] p);
        if (p >= 8'h30 && p <= 8'h71 && !gate_ok()) return "R4";
        case (p)
            8'h07, 8'h20, 8'h27: return "R3";
            8'h30: return "R5";
            8'h60, 8'h61: return "R6";
            8'h70: return "R7";
            8'h71: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        m_ptr = 0; m_dev = 0; m_bh = 0; m_irq = 0; m_bl = 0; m_act = 0; m_t1 = 1;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a == b_ptr) m_ptr = d;
        else if (a == b_dat) begin
            if (m_ptr == 8'h07) m_dev = d;
            else if (gate_ok()) begin
                case (m_ptr)
                    8'h30: m_act = d[0];
                    8'h60: m_bh = d;
                    8'h61: m_bl = d[7:4];
                    8'h70: m_irq = d;
                    8'h71: m_t1 = d[1];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic check_outs();
        check("R5 dev_active", {15'b0, dev_active}, {15'b0, m_act});
        check("R6 io_base", io_base, {m_bh, m_bl, 4'h0});
        check("R6 io_base_vld", {15'b0, io_base_vld}, {15'b0, m_act});
        check("R7 irq_sel", {8'b0, irq_sel}, {8'b0, m_irq});
        check("R8 irq_type", {8'b0, irq_type}, {8'b0, 6'b0, m_t1, 1'b1});
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        model_write(a, d);
        check_outs();
    endtask

    // Read and compare; response is registered, visible at the next negedge
    task automatic do_rd(input logic [15:0] a, input string tag);
        logic hit;
        logic [7:0] exp;
        hit = (a == b_ptr) || (a == b_dat);
        exp = (a == b_ptr) ? m_ptr : (a == b_dat) ? exp_data(m_ptr) : 8'h00;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check({tag, " R10 rvalid"}, {15'b0, io_rvalid}, {15'b0, hit});
        check({tag, " rdata"}, {8'b0, io_rdata}, {8'b0, exp});
        @(negedge clk);
        check("R10 idle rdata", {7'b0, io_rvalid, io_rdata}, 16'h0000);
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0; strap_hi = s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        b_ptr = s ? 16'h007E : 16'h00EE;
        b_dat = b_ptr + 16'd1;
        model_reset();
    endtask

    function automatic logic [7:0] pick_ptr();
        case ($urandom_range(0, 9))
            0: return 8'h07; 1: return 8'h20; 2: return 8'h27; 3: return 8'h30;
            4: return 8'h60; 5: return 8'h61; 6: return 8'h70; 7: return 8'h71;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic random_ops(input int n);
        for (int i = 0; i < n; i++) begin
            int kind = $urandom_range(0, 9);
            logic [15:0] other = 16'($urandom);
            if (other == b_ptr || other == b_dat) other = other ^ 16'h0100;
            case (kind)
                0, 1: do_wr(b_ptr, pick_ptr());
                2, 3: begin
                    logic [7:0] d = 8'($urandom);
                    if (m_ptr == 8'h07 && $urandom_range(0, 9) < 7) d = 8'h1A;
                    do_wr(b_dat, d);
                end
                4: do_rd(b_ptr, "R1");
                5, 6: do_rd(b_dat, tag_of(m_ptr));
                7: do_wr(other, 8'($urandom));
                8: do_rd(other, "R2");
                default: begin
                    do_wr(b_ptr, pick_ptr());
                    do_rd(b_dat, tag_of(m_ptr));
                end
            endcase
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'h5EED_0042);
        do_reset(1'b1);
        @(negedge clk);
        check_outs();                              // reset values R5..R8
        do_rd(16'h007E, "R1 reset");
        do_rd(16'h007F, "R9 ptr00");
        do_wr(16'h007E, 8'h20); do_rd(16'h007F, "R3 devid");
        do_wr(16'h007F, 8'h00); do_rd(16'h007F, "R3 devid ro");
        do_wr(16'h007E, 8'h27); do_rd(16'h007F, "R3 revid");
        do_wr(16'h007E, 8'h30); do_wr(16'h007F, 8'h01);
        do_rd(16'h007F, "R4 gated act");
        do_wr(16'h007E, 8'h07); do_wr(16'h007F, 8'h1A); do_rd(16'h007F, "R3 devnum");
        do_wr(16'h007E, 8'h30); do_wr(16'h007F, 8'hFF); do_rd(16'h007F, "R5 act");
        do_wr(16'h007E, 8'h61); do_wr(16'h007F, 8'hFF); do_rd(16'h007F, "R6 low nibble");
        do_wr(16'h007E, 8'h60); do_wr(16'h007F, 8'hC3); do_rd(16'h007F, "R6 high");
        do_wr(16'h007E, 8'h71); do_wr(16'h007F, 8'h00); do_rd(16'h007F, "R8 clear");
        do_wr(16'h007F, 8'hFF); do_rd(16'h007F, "R8 set");
        do_wr(16'h007E, 8'h70); do_wr(16'h007F, 8'hA5); do_rd(16'h007F, "R7 irq");
        do_wr(16'h007E, 8'h31); do_wr(16'h007F, 8'h55); do_rd(16'h007F, "R9 gap");
        do_wr(16'h007E, 8'h45); do_wr(16'h007F, 8'h55); do_rd(16'h007F, "R9 unimpl");
        do_wr(16'h00EE, 8'h07); do_rd(16'h007E, "R2 other pair");
        do_wr(16'h007E, 8'h07); do_wr(16'h007F, 8'h00);
        do_wr(16'h007E, 8'h60); do_rd(16'h007F, "R4 closed");
        do_wr(16'h007F, 8'h12); do_rd(16'h007F, "R4 closed wr");
        random_ops(400);

        do_reset(1'b0);
        @(negedge clk);
        check_outs();
        strap_hi = 1'b1;                           // change after reset: ignored
        do_rd(16'h007E, "R2 strap held");
        do_rd(16'h00EE, "R2 low base");
        do_wr(16'h00EE, 8'h07); do_wr(16'h00EF, 8'h1A); do_rd(16'h00EF, "R2 low data");
        random_ops(300);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule